// File: doc/BRIEF.md
# Scanline Video Memory Slot Sequencer

This block tells the video memory controller what kind of access to make in each memory slot of a scanline. A slot strobe moves it forward by one slot, and a line-start pulse brings it back to slot zero. For every slot it gives a kind code, plus the background column, the sprite index and the tile word select that go with that kind. It also asserts a grant in each slot that belongs to the CPU port, and drives an active-low horizontal sync level that changes on slot boundaries. Address generation and pixel output are left to other blocks.

One line has 171 slots. The first part of the line holds sprite rendering blocks of six slots each. Each of these blocks serves two of the eight sprites selected for the line. Between them sits a group of CPU slots in which horizontal sync falls. Next come eight sprite Y-pair reads. These are followed by eight background blocks of sixteen slots each, and each background block fetches four columns. Within the background blocks, the second slot of each column is either a CPU slot or another sprite Y-pair read, so the Y scan over all 64 sprites finishes inside the line. No slot of the line is spent on memory refresh.

Top module: `vram_slot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to slot 0 and the outputs show slot 0: kind 3, sprite 0, column 0, word 0, no grant, `hsync_n` high.
- R2: The slot counter changes only on clock edges where `slot_en` is high. With `slot_en` high, `line_start` loads slot 0, and otherwise the counter steps by one and wraps from 170 to 0. When `slot_en` is low, `line_start` has no effect.
- R3: Slots 0–11 and 17–28 form four sprite blocks that serve active sprites 0–1, 2–3, 4–5 and 6–7. In each block the order is: the attribute read of the first sprite, the attribute read of the second sprite, then the two tile words of the first sprite, then the two tile words of the second sprite.
- R4: A tile row always takes two consecutive slots of the same kind and index. `word_sel` is 0 in the first slot and 1 in the second.
- R5: Slots 39–166 form 8 background blocks. In block j, column c (c = 0..3) uses four slots: a name read of column 4j+c, then a filler slot, then the two tile words. The filler slot is a CPU slot when c = 0 and a Y-pair read of sprite 16+6j+2(c−1) otherwise.
- R6: Slots 31–38 are Y-pair reads of sprites 0, 2, 4, … 14, in that order.
- R7: Slots 12–16, 29–30 and 167–170 are CPU slots, as are the c = 0 filler slots. `ext_grant` is high exactly in the slots of kind 0.
- R8: `hsync_n` is low in slots 14 to 26 and high in all other slots, so it rises at the slot of the first tile word of active sprite 7.
- R9: Kind codes are 0 CPU, 1 background name, 2 background tile word, 3 sprite attribute, 4 sprite tile word and 5 sprite Y-pair. `col_idx` is zero unless the kind is 1 or 2. `spr_idx` is zero for kinds 0, 1 and 2. `word_sel` is zero unless the kind is 2 or 4.
- R10: Every slot has one of the six kinds, and no refresh kind exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Slot strobe; the sequence steps on clock edges where this is high |
| line_start | input | 1 | Loads slot 0 when sampled together with `slot_en` |
| slot_idx | output | 8 | Current slot number within the line |
| slot_kind | output | 3 | Access kind code of the current slot |
| col_idx | output | 5 | Background column for name and tile slots |
| spr_idx | output | 6 | Active sprite number (kinds 3, 4) or first sprite of the Y pair (kind 5) |
| word_sel | output | 1 | Tile word select, 0 then 1 |
| ext_grant | output | 1 | The slot belongs to the CPU access port |
| hsync_n | output | 1 | Horizontal sync, active low |

## Verification
The bench checks every output in every slot of the line. It first runs two lines with an unbroken strobe, which covers the wrap from slot 170 to slot 0. A run with the strobe present one cycle in three then shows whether any output moves without a strobe. A `line_start` with no strobe must leave the slot unchanged, while a `line_start` with a strobe in the middle of a line must restart it. These two cases separate restart handling from plain counting. A reset in the middle of a line shows that reset brings back the slot-0 state no matter where the counter was.

// File: rtl/vslot_pkg.sv
package vslot_pkg;
  typedef enum logic [2:0] {
    SK_EXT      = 3'd0,
    SK_BG_NAME  = 3'd1,
    SK_BG_TILE  = 3'd2,
    SK_SPR_ATTR = 3'd3,
    SK_SPR_TILE = 3'd4,
    SK_SPR_Y    = 3'd5
  } slot_kind_e;

  localparam int SPR_BLK_LEN = 6;
  localparam int BG_BLK_LEN  = 16;
  localparam int COL_LEN     = 4;
endpackage

// File: rtl/vslot_counter.sv
module vslot_counter #(
  parameter int LINE_SLOTS = 171,
  parameter int SLOT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_en,
  input  logic              line_start,
  output logic [SLOT_W-1:0] cnt_nxt,
  output logic [SLOT_W-1:0] cnt
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(LINE_SLOTS - 1);

  always_comb begin
    if (rst)                cnt_nxt = '0;
    else if (!slot_en)      cnt_nxt = cnt;
    else if (line_start)    cnt_nxt = '0;
    else if (cnt == LAST)   cnt_nxt = '0;
    else                    cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_nxt;
  end
endmodule

// File: rtl/vslot_spr_dec.sv
module vslot_spr_dec
  import vslot_pkg::*;
#(
  parameter int SPR_W = 6
) (
  input  logic [2:0]       off,
  input  logic [SPR_W-1:0] first_idx,
  output slot_kind_e       kind,
  output logic [SPR_W-1:0] idx,
  output logic             word
);
  always_comb begin
    kind = SK_SPR_ATTR;
    idx  = first_idx;
    word = 1'b0;
    if (off < 3'd2) begin
      idx = first_idx + SPR_W'(off[0]);
    end else begin
      kind = SK_SPR_TILE;
      idx  = first_idx + SPR_W'(off >= 3'd4);
      word = off[0];
    end
  end
endmodule

// File: rtl/vslot_bg_dec.sv
module vslot_bg_dec
  import vslot_pkg::*;
#(
  parameter int BW     = 3,
  parameter int SPR_W  = 6,
  parameter int Y_BASE = 16
) (
  input  logic [BW-1:0]    blk,
  input  logic [3:0]       off,
  output slot_kind_e       kind,
  output logic [BW+1:0]    col,
  output logic [SPR_W-1:0] spr,
  output logic             word
);
  logic [1:0] c;
  logic [1:0] k;

  assign c = off[3:2];
  assign k = off[1:0];

  always_comb begin
    kind = SK_EXT;
    col  = '0;
    spr  = '0;
    word = 1'b0;
    unique case (k)
      2'd0: begin
        kind = SK_BG_NAME;
        col  = {blk, c};
      end
      2'd1: begin
        if (c != 2'd0) begin
          kind = SK_SPR_Y;
          spr  = SPR_W'(Y_BASE + 6 * int'(blk) + 2 * (int'(c) - 1));
        end
      end
      default: begin
        kind = SK_BG_TILE;
        col  = {blk, c};
        word = k[0];
      end
    endcase
  end
endmodule

// File: rtl/vslot_decode.sv
module vslot_decode
  import vslot_pkg::*;
#(
  parameter int SLOT_W      = 8,
  parameter int SPR_W       = 6,
  parameter int BW          = 3,
  parameter int SPR_A_END   = 12,
  parameter int SPR_B_START = 17,
  parameter int SPR_B_END   = 29,
  parameter int SPR_A_SPR   = 4,
  parameter int HS_FALL     = 14,
  parameter int HS_RISE     = 27,
  parameter int Y_START     = 31,
  parameter int BG_START    = 39,
  parameter int BG_END      = 167,
  parameter int Y_BASE      = 16
) (
  input  logic [SLOT_W-1:0] slot,
  output slot_kind_e        kind,
  output logic [BW+1:0]     col,
  output logic [SPR_W-1:0]  spr,
  output logic              word,
  output logic              hs_n
);
  int s, spr_rel, bg_rel;
  logic in_spr_a, in_spr_b, in_y, in_bg;
  logic [2:0]       spr_off;
  logic [SPR_W-1:0] spr_first;
  logic [BW-1:0]    bg_blk;
  logic [3:0]       bg_off;

  slot_kind_e       sp_kind, bg_kind;
  logic [SPR_W-1:0] sp_idx, bg_spr;
  logic             sp_word, bg_word;
  logic [BW+1:0]    bg_col;

  always_comb begin
    s        = int'(slot);
    in_spr_a = s < SPR_A_END;
    in_spr_b = (s >= SPR_B_START) && (s < SPR_B_END);
    in_y     = (s >= Y_START) && (s < BG_START);
    in_bg    = (s >= BG_START) && (s < BG_END);
    spr_rel  = in_spr_a ? s : (in_spr_b ? s - SPR_B_START : 0);
    spr_off  = 3'(spr_rel % SPR_BLK_LEN);
    spr_first = SPR_W'((in_spr_a ? 0 : SPR_A_SPR) + 2 * (spr_rel / SPR_BLK_LEN));
    bg_rel   = in_bg ? s - BG_START : 0;
    bg_off   = 4'(bg_rel % BG_BLK_LEN);
    bg_blk   = BW'(bg_rel / BG_BLK_LEN);
    hs_n     = !((s >= HS_FALL) && (s < HS_RISE));
  end

  vslot_spr_dec #(.SPR_W(SPR_W)) u_spr (
    .off       (spr_off),
    .first_idx (spr_first),
    .kind      (sp_kind),
    .idx       (sp_idx),
    .word      (sp_word)
  );

  vslot_bg_dec #(.BW(BW), .SPR_W(SPR_W), .Y_BASE(Y_BASE)) u_bg (
    .blk  (bg_blk),
    .off  (bg_off),
    .kind (bg_kind),
    .col  (bg_col),
    .spr  (bg_spr),
    .word (bg_word)
  );

  always_comb begin
    kind = SK_EXT;
    col  = '0;
    spr  = '0;
    word = 1'b0;
    if (in_spr_a || in_spr_b) begin
      kind = sp_kind;
      spr  = sp_idx;
      word = sp_word;
    end else if (in_y) begin
      kind = SK_SPR_Y;
      spr  = SPR_W'(2 * (s - Y_START));
    end else if (in_bg) begin
      kind = bg_kind;
      col  = bg_col;
      spr  = bg_spr;
      word = bg_word;
    end
  end
endmodule

// File: rtl/vram_slot_seq.sv
module vram_slot_seq
  import vslot_pkg::*;
#(
  parameter int SPR_BLKS_A = 2,
  parameter int GAP_A      = 2,
  parameter int HS_EXT     = 3,
  parameter int SPR_BLKS_B = 2,
  parameter int GAP_B      = 2,
  parameter int Y_LEAD     = 8,
  parameter int BG_BLKS    = 8,
  parameter int TAIL       = 4,
  localparam int SPR_A_END   = SPR_BLKS_A * SPR_BLK_LEN,
  localparam int HS_FALL     = SPR_A_END + GAP_A,
  localparam int SPR_B_START = HS_FALL + HS_EXT,
  localparam int SPR_B_END   = SPR_B_START + SPR_BLKS_B * SPR_BLK_LEN,
  localparam int HS_RISE     = SPR_B_END - 2,
  localparam int Y_START     = SPR_B_END + GAP_B,
  localparam int BG_START    = Y_START + Y_LEAD,
  localparam int BG_END      = BG_START + BG_BLKS * BG_BLK_LEN,
  localparam int LINE_SLOTS  = BG_END + TAIL,
  localparam int ACTIVE      = 2 * (SPR_BLKS_A + SPR_BLKS_B),
  localparam int SPRITES     = 2 * Y_LEAD + 6 * BG_BLKS,
  localparam int SLOT_W      = $clog2(LINE_SLOTS),
  localparam int BW          = (BG_BLKS > 1) ? $clog2(BG_BLKS) : 1,
  localparam int COL_W       = BW + 2,
  localparam int SPR_W       = $clog2((SPRITES > ACTIVE) ? SPRITES : ACTIVE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_en,
  input  logic              line_start,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [2:0]        slot_kind,
  output logic [COL_W-1:0]  col_idx,
  output logic [SPR_W-1:0]  spr_idx,
  output logic              word_sel,
  output logic              ext_grant,
  output logic              hsync_n
);
  logic [SLOT_W-1:0] cnt_nxt;
  slot_kind_e        d_kind;
  logic [COL_W-1:0]  d_col;
  logic [SPR_W-1:0]  d_spr;
  logic              d_word, d_hs_n;

  vslot_counter #(.LINE_SLOTS(LINE_SLOTS), .SLOT_W(SLOT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .slot_en    (slot_en),
    .line_start (line_start),
    .cnt_nxt    (cnt_nxt),
    .cnt        (slot_idx)
  );

  vslot_decode #(
    .SLOT_W(SLOT_W), .SPR_W(SPR_W), .BW(BW),
    .SPR_A_END(SPR_A_END), .SPR_B_START(SPR_B_START), .SPR_B_END(SPR_B_END),
    .SPR_A_SPR(2 * SPR_BLKS_A), .HS_FALL(HS_FALL), .HS_RISE(HS_RISE),
    .Y_START(Y_START), .BG_START(BG_START), .BG_END(BG_END), .Y_BASE(2 * Y_LEAD)
  ) u_dec (
    .slot (cnt_nxt),
    .kind (d_kind),
    .col  (d_col),
    .spr  (d_spr),
    .word (d_word),
    .hs_n (d_hs_n)
  );

  always_ff @(posedge clk) begin
    if (rst || slot_en) begin
      slot_kind <= d_kind;
      col_idx   <= d_col;
      spr_idx   <= d_spr;
      word_sel  <= d_word;
      ext_grant <= (d_kind == SK_EXT);
      hsync_n   <= d_hs_n;
    end
  end
endmodule

// File: rtl/vslot_checker.sv
module vslot_checker #(
  parameter int SLOT_W     = 8,
  parameter int COL_W      = 5,
  parameter int SPR_W      = 6,
  parameter int LINE_SLOTS = 171,
  parameter int HS_FALL    = 14,
  parameter int HS_RISE    = 27,
  parameter int ACTIVE     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_en,
  input logic              line_start,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [2:0]        slot_kind,
  input logic [COL_W-1:0]  col_idx,
  input logic [SPR_W-1:0]  spr_idx,
  input logic              word_sel,
  input logic              ext_grant,
  input logic              hsync_n
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !slot_en |=> $stable(slot_idx) && $stable(slot_kind) && $stable(hsync_n));

  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    slot_en && line_start |=> slot_idx == '0);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    slot_en && !line_start && (int'(slot_idx) == LINE_SLOTS - 1) |=> slot_idx == '0);

  p_attr_range_r3: assert property (@(posedge clk) disable iff (rst)
    (slot_kind == 3'd3) |-> (int'(spr_idx) < ACTIVE));

  p_tile_pair_r4: assert property (@(posedge clk) disable iff (rst)
    slot_en && !line_start && ((slot_kind == 3'd2) || (slot_kind == 3'd4)) && !word_sel
    |=> word_sel && $stable(slot_kind) && $stable(spr_idx) && $stable(col_idx));

  p_grant_r7: assert property (@(posedge clk) disable iff (rst)
    ext_grant == (slot_kind == 3'd0));

  p_hs_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> int'(slot_idx) == HS_FALL);

  p_hs_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> (int'(slot_idx) == HS_RISE) && (slot_kind == 3'd4) && !word_sel);

  p_kind_legal_r10: assert property (@(posedge clk) disable iff (rst)
    slot_kind <= 3'd5);
endmodule

bind vram_slot_seq vslot_checker #(
  .SLOT_W(SLOT_W), .COL_W(COL_W), .SPR_W(SPR_W), .LINE_SLOTS(LINE_SLOTS),
  .HS_FALL(HS_FALL), .HS_RISE(HS_RISE), .ACTIVE(ACTIVE)
) u_chk (
  .clk(clk), .rst(rst), .slot_en(slot_en), .line_start(line_start),
  .slot_idx(slot_idx), .slot_kind(slot_kind), .col_idx(col_idx),
  .spr_idx(spr_idx), .word_sel(word_sel), .ext_grant(ext_grant), .hsync_n(hsync_n)
);

// File: tb/sim_vram_slot_seq.sv
`timescale 1ns/1ps
module sim_vram_slot_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_en = 1'b0;
  logic       line_start = 1'b0;
  logic [7:0] slot_idx;
  logic [2:0] slot_kind;
  logic [4:0] col_idx;
  logic [5:0] spr_idx;
  logic       word_sel, ext_grant, hsync_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int cur    = 0;

  always #2.5 clk = ~clk;

  vram_slot_seq u0 (
    .clk(clk), .rst(rst), .slot_en(slot_en), .line_start(line_start),
    .slot_idx(slot_idx), .slot_kind(slot_kind), .col_idx(col_idx),
    .spr_idx(spr_idx), .word_sel(word_sel), .ext_grant(ext_grant), .hsync_n(hsync_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual %0d cycles, expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Expected fields of slot s, worked out from the line layout.
  task automatic model(input int s, output int ty, output int col, output int sp,
                       output int ws, output int hs);
    int base, r, b, o, j, c, k;
    ty = 0; col = 0; sp = 0; ws = 0;
    hs = (s >= 14 && s < 27) ? 0 : 1;
    if (s < 12 || (s >= 17 && s < 29)) begin
      base = (s < 12) ? 0 : 4;
      r = (s < 12) ? s : s - 17;
      b = r / 6;
      o = r % 6;
      if (o < 2) begin
        ty = 3; sp = base + 2 * b + o;
      end else begin
        ty = 4; sp = base + 2 * b + (o - 2) / 2; ws = (o - 2) % 2;
      end
    end else if (s >= 31 && s < 39) begin
      ty = 5; sp = 2 * (s - 31);
    end else if (s >= 39 && s < 167) begin
      r = s - 39;
      j = r / 16;
      c = (r % 16) / 4;
      k = r % 4;
      if (k == 0) begin
        ty = 1; col = 4 * j + c;
      end else if (k == 1) begin
        if (c != 0) begin
          ty = 5; sp = 16 + 6 * j + 2 * (c - 1);
        end
      end else begin
        ty = 2; col = 4 * j + c; ws = k - 2;
      end
    end
  endtask

  task automatic chk(input int s, input string req);
    int ty, col, sp, ws, hs;
    string tag;
    model(s, ty, col, sp, ws, hs);
    checks++;
    if (req != "") tag = req;
    else if (int'(hsync_n) != hs) tag = "R8";
    else if (ty == 3) tag = "R3/R9";
    else if (ty == 4) tag = "R4/R9";
    else if (ty == 5 && s < 39) tag = "R6";
    else if (ty == 1 || ty == 2 || ty == 5) tag = "R5/R9";
    else tag = "R7";
    if (slot_kind > 3'd5) begin
      fails++;
      $display("FAIL R10 slot %0d: kind actual %0d expected <= 5", s, slot_kind);
    end else if (int'(slot_idx) != s || int'(slot_kind) != ty || int'(col_idx) != col ||
        int'(spr_idx) != sp || int'(word_sel) != ws || int'(hsync_n) != hs ||
        ext_grant != (ty == 0)) begin
      fails++;
      $display("FAIL %s: actual slot=%0d kind=%0d col=%0d spr=%0d word=%0d hs=%0d grant=%0d, expected slot=%0d kind=%0d col=%0d spr=%0d word=%0d hs=%0d grant=%0d",
               (int'(slot_idx) != s) ? "R2" : tag,
               slot_idx, slot_kind, col_idx, spr_idx, word_sel, hsync_n, ext_grant,
               s, ty, col, sp, ws, hs, (ty == 0));
    end
  endtask

  task automatic strobe(input bit en, input bit ls);
    slot_en = en;
    line_start = ls;
    @(posedge clk);
    #1;
    slot_en = 1'b0;
    line_start = 1'b0;
    if (en) cur = ls ? 0 : (cur + 1) % 171;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(0, "R1");                                  // R1: reset state
    cur = 0;
    // Two full lines without gaps, covering the wrap (R2)
    for (int i = 0; i < 342; i++) begin
      strobe(1'b1, 1'b0);
      chk(cur, "");
    end
    // Strobe one cycle in three: outputs hold in between (R2)
    for (int i = 0; i < 300; i++) begin
      strobe((i % 3) == 0, 1'b0);
      chk(cur, (i % 3) == 0 ? "" : "R2");
    end
    // line_start without strobe is ignored (R2)
    strobe(1'b0, 1'b1);
    chk(cur, "R2");
    // Advance to slot 100, then restart mid-line (R2)
    while (cur != 100) strobe(1'b1, 1'b0);
    chk(cur, "");
    strobe(1'b1, 1'b1);
    chk(0, "R2");
    for (int i = 0; i < 171; i++) begin
      strobe(1'b1, 1'b0);
      chk(cur, "");
    end
    // Reset mid-line with a strobe present (R1)
    while (cur != 60) strobe(1'b1, 1'b0);
    rst = 1'b1;
    strobe(1'b1, 1'b0);
    rst = 1'b0;
    cur = 0;
    chk(0, "R1");
    strobe(1'b1, 1'b0);
    chk(1, "");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule